// File: doc/BRIEF.md
# Absorption Loop Set Point, Stepper and Correction Filter

This block is the digital front end of a running write-power optimisation loop in an optical recorder. Each signed absorption sample from an external converter is multiplied by a programmable input gain. The scaled sample is subtracted from a set point to form an error. A first-order integrator multiplies the error by a programmable loop gain, shifts the product right by a fixed amount and adds the result to a running write-power correction. The correction is then bounded by programmable lower and upper limits.

The set point is either a plain register value or the output of a stepper. Each rising edge of an asynchronous calibration strobe advances the stepper by a programmed increment until a programmed number of advances has been made. A separate asynchronous zeroing input acts in one of two ways, chosen by a mode bit: it freezes the integrator by forcing the error to zero, or it drops the set point out of the error sum. When a sample update saturates at a limit, a sticky flag is set. That flag can drive an interrupt line through an enable mask.

Top module: `alpha_loop_ctl`

## Requirements
- R1: During and directly after reset, `corr` is 0 and `at_limit`, `clamp_sticky` and `irq` are 0.
- R2: On a clock edge where `smp_valid` is 1, `corr` becomes corr + ((sp − code·in_gain)·loop_gain >>> 2). The shift is arithmetic and rounds toward minus infinity. `smp_code` is two's complement (−128 means no input current, +127 means nominal full current). `in_gain` and `loop_gain` are unsigned 0 to 15. The new value is visible after that edge.
- R3: While `smp_valid` is 0, `corr` does not change.
- R4: A result above `corr_max` is replaced by `corr_max`, and a result below `corr_min` is replaced by `corr_min`; `at_limit` is 1 after such an update and 0 after an update that was not bounded. This assumes `corr_min` ≤ `corr_max`.
- R5: `clamp_sticky` is set by any bounded update and stays set until a cycle with `clamp_clr` = 1 clears it. A bounded update in the same cycle as `clamp_clr` wins. `irq` equals `clamp_sticky` AND `clamp_irq_en`.
- R6: With `sp_sel` = 0, the set point is `sp_reg`, and `sp_active` shows it.
- R7: While `sp_sel` = 0, the stepper reloads `step_start` and clears its advance count. With `sp_sel` = 1, `sp_active` shows the stepper value. That value grows by `step_size` once per rising edge of `opc_strobe`, and a strobe held high gives only one advance.
- R8: After `step_limit` advances, further strobe edges leave the stepper value unchanged.
- R9: With `aez` = 1 and `aez_mode` = 0, the error is zero, so valid samples leave `corr` unchanged while it lies inside the limits.
- R10: With `aez` = 1 and `aez_mode` = 1, the set point in the error sum is zero, so the error is −code·in_gain.
- R11: `opc_strobe` and `aez` pass through a two-flop synchronizer. Their effect appears no later than three clock edges after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New absorption sample present |
| smp_code | input | 8 | Signed absorption sample |
| in_gain | input | 4 | Input scaling factor |
| loop_gain | input | 4 | Integrator gain |
| sp_sel | input | 1 | 0: register set point, 1: stepper |
| sp_reg | input | 12 | Signed register set point |
| step_start | input | 12 | Signed stepper start value |
| step_size | input | 12 | Signed stepper increment |
| step_limit | input | 6 | Maximum number of stepper advances |
| opc_strobe | input | 1 | Asynchronous stepper strobe |
| aez | input | 1 | Asynchronous zeroing request |
| aez_mode | input | 1 | 0: zero the error, 1: zero the set point |
| corr_min | input | 16 | Signed lower correction limit |
| corr_max | input | 16 | Signed upper correction limit |
| clamp_irq_en | input | 1 | Interrupt mask for the sticky flag |
| clamp_clr | input | 1 | Clears the sticky flag |
| sp_active | output | 12 | Selected set point |
| corr | output | 16 | Signed write-power correction |
| at_limit | output | 1 | Last update was bounded |
| clamp_sticky | output | 1 | A bounded update occurred |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check four things on every cycle. The correction stays inside the limits that applied to its last update. The correction does not move without a sample, or while the synchronized zeroing request in error mode is active. The sticky flag only falls through a clear. The stepper output moves only on a strobe, or else reloads the start value when deselected. The bench scenarios cover the rest. They show the exact arithmetic of the integrator for positive, negative and odd-gain products, and how the set-point zeroing mode changes the error. They also show the stepper's per-edge increments, where it stops at its limit, and how the interrupt mask gates the flag.

// File: rtl/alpha_pkg.sv
package alpha_pkg;
  parameter int unsigned SMP_W_D  = 8;
  parameter int unsigned IG_W_D   = 4;
  parameter int unsigned LG_W_D   = 4;
  parameter int unsigned SP_W_D   = 12;
  parameter int unsigned CORR_W_D = 16;
  parameter int unsigned CNT_W_D  = 6;
  parameter int unsigned SHIFT_D  = 2;
  parameter int unsigned SYNC_D   = 2;

  typedef enum logic {
    AEZ_HOLD_ERR = 1'b0,
    AEZ_ZERO_SP  = 1'b1
  } aez_mode_e;
endpackage

// File: rtl/alpha_sync.sv
module alpha_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/opc_stepper.sv
module opc_stepper #(
  parameter int unsigned SP_W  = 12,
  parameter int unsigned CNT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    strobe_lvl,
  input  logic signed [SP_W-1:0]  start_val,
  input  logic signed [SP_W-1:0]  incr,
  input  logic        [CNT_W-1:0] max_adv,
  output logic signed [SP_W-1:0]  value
);
  logic signed [SP_W-1:0]  val_q, val_d;
  logic        [CNT_W-1:0] cnt_q, cnt_d;
  logic                    last_q;
  logic                    adv;

  always_comb begin
    adv   = strobe_lvl & ~last_q;
    val_d = val_q;
    cnt_d = cnt_q;
    if (!enable) begin
      val_d = start_val;
      cnt_d = '0;
    end else if (adv && (cnt_q < max_adv)) begin
      val_d = val_q + incr;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      cnt_q  <= cnt_d;
      last_q <= strobe_lvl;
    end
  end

  assign value = val_q;
endmodule

// File: rtl/alpha_filter.sv
module alpha_filter #(
  parameter int unsigned SMP_W  = 8,
  parameter int unsigned IG_W   = 4,
  parameter int unsigned LG_W   = 4,
  parameter int unsigned SP_W   = 12,
  parameter int unsigned CORR_W = 16,
  parameter int unsigned SHIFT  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [SMP_W-1:0]  smp_code,
  input  logic        [IG_W-1:0]   in_gain,
  input  logic        [LG_W-1:0]   loop_gain,
  input  logic signed [SP_W-1:0]   setpoint,
  input  logic                     hold_err,
  input  logic                     zero_sp,
  input  logic signed [CORR_W-1:0] corr_min,
  input  logic signed [CORR_W-1:0] corr_max,
  output logic signed [CORR_W-1:0] corr,
  output logic                     clamp_now,
  output logic                     at_limit
);
  localparam int unsigned SC_W   = SMP_W + IG_W + 1;
  localparam int unsigned ERR_W  = ((SP_W > SC_W) ? SP_W : SC_W) + 1;
  localparam int unsigned PROD_W = ERR_W + LG_W + 1;
  localparam int unsigned ACC_W  = ((CORR_W > PROD_W) ? CORR_W : PROD_W) + 1;

  logic signed [SC_W-1:0]   scaled;
  logic signed [SP_W-1:0]   sp_eff;
  logic signed [ERR_W-1:0]  err;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] delta;
  logic signed [ACC_W-1:0]  acc;
  logic signed [CORR_W-1:0] corr_q, corr_d;
  logic                     lim_q;

  always_comb begin
    scaled = SC_W'(smp_code) * $signed(SC_W'(in_gain));
    sp_eff = zero_sp ? '0 : setpoint;
    err    = hold_err ? '0 : (ERR_W'(sp_eff) - ERR_W'(scaled));
    prod   = PROD_W'(err) * $signed(PROD_W'(loop_gain));
    delta  = prod >>> SHIFT;
    acc    = ACC_W'(corr_q) + ACC_W'(delta);
    clamp_now = 1'b1;
    if (acc > ACC_W'(corr_max)) begin
      corr_d = corr_max;
    end else if (acc < ACC_W'(corr_min)) begin
      corr_d = corr_min;
    end else begin
      corr_d    = CORR_W'(acc);
      clamp_now = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
      lim_q  <= 1'b0;
    end else if (smp_valid) begin
      corr_q <= corr_d;
      lim_q  <= clamp_now;
    end
  end

  assign corr     = corr_q;
  assign at_limit = lim_q;
endmodule

// File: rtl/alpha_loop_ctl.sv
module alpha_loop_ctl
  import alpha_pkg::*;
#(
  parameter int unsigned SMP_W  = SMP_W_D,
  parameter int unsigned IG_W   = IG_W_D,
  parameter int unsigned LG_W   = LG_W_D,
  parameter int unsigned SP_W   = SP_W_D,
  parameter int unsigned CORR_W = CORR_W_D,
  parameter int unsigned CNT_W  = CNT_W_D,
  parameter int unsigned SHIFT  = SHIFT_D,
  parameter int unsigned SYNC   = SYNC_D
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [SMP_W-1:0]  smp_code,
  input  logic        [IG_W-1:0]   in_gain,
  input  logic        [LG_W-1:0]   loop_gain,
  input  logic                     sp_sel,
  input  logic signed [SP_W-1:0]   sp_reg,
  input  logic signed [SP_W-1:0]   step_start,
  input  logic signed [SP_W-1:0]   step_size,
  input  logic        [CNT_W-1:0]  step_limit,
  input  logic                     opc_strobe,
  input  logic                     aez,
  input  logic                     aez_mode,
  input  logic signed [CORR_W-1:0] corr_min,
  input  logic signed [CORR_W-1:0] corr_max,
  input  logic                     clamp_irq_en,
  input  logic                     clamp_clr,
  output logic signed [SP_W-1:0]   sp_active,
  output logic signed [CORR_W-1:0] corr,
  output logic                     at_limit,
  output logic                     clamp_sticky,
  output logic                     irq
);
  logic                   opc_lvl;
  logic                   aez_lvl;
  logic signed [SP_W-1:0] step_val;
  logic                   hold_err;
  logic                   zero_sp;
  logic                   clamp_now;
  logic                   sticky_q, sticky_d;

  alpha_sync #(.STAGES(SYNC)) u_sync_opc (
    .clk(clk), .rst_n(rst_n), .d(opc_strobe), .q(opc_lvl)
  );

  alpha_sync #(.STAGES(SYNC)) u_sync_aez (
    .clk(clk), .rst_n(rst_n), .d(aez), .q(aez_lvl)
  );

  opc_stepper #(.SP_W(SP_W), .CNT_W(CNT_W)) u_step (
    .clk(clk), .rst_n(rst_n), .enable(sp_sel), .strobe_lvl(opc_lvl),
    .start_val(step_start), .incr(step_size), .max_adv(step_limit),
    .value(step_val)
  );

  always_comb begin
    sp_active = sp_sel ? step_val : sp_reg;
    hold_err  = aez_lvl && (aez_mode == AEZ_HOLD_ERR);
    zero_sp   = aez_lvl && (aez_mode == AEZ_ZERO_SP);
  end

  alpha_filter #(
    .SMP_W(SMP_W), .IG_W(IG_W), .LG_W(LG_W), .SP_W(SP_W),
    .CORR_W(CORR_W), .SHIFT(SHIFT)
  ) u_filt (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .in_gain(in_gain), .loop_gain(loop_gain), .setpoint(sp_active),
    .hold_err(hold_err), .zero_sp(zero_sp), .corr_min(corr_min),
    .corr_max(corr_max), .corr(corr), .clamp_now(clamp_now),
    .at_limit(at_limit)
  );

  always_comb begin
    sticky_d = sticky_q;
    if (clamp_clr)                sticky_d = 1'b0;
    if (smp_valid && clamp_now)   sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  assign clamp_sticky = sticky_q;
  assign irq          = sticky_q & clamp_irq_en;
endmodule

// File: rtl/alpha_loop_chk.sv
module alpha_loop_chk #(
  parameter int unsigned SP_W   = 12,
  parameter int unsigned CORR_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_valid,
  input logic                     sp_sel,
  input logic                     opc_lvl,
  input logic                     hold_err,
  input logic                     clamp_clr,
  input logic                     clamp_sticky,
  input logic signed [CORR_W-1:0] corr,
  input logic signed [CORR_W-1:0] corr_min,
  input logic signed [CORR_W-1:0] corr_max,
  input logic signed [SP_W-1:0]   sp_active,
  input logic signed [SP_W-1:0]   step_start
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_corr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(smp_valid)) |->
      (corr <= $past(corr_max) && corr >= $past(corr_min)));

  assert_corr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !smp_valid) |=> $stable(corr));

  assert_aez_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && smp_valid && hold_err && corr <= corr_max && corr >= corr_min)
      |=> $stable(corr));

  assert_sticky_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && clamp_sticky && !clamp_clr) |=> clamp_sticky);

  assert_step_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && sp_sel && !opc_lvl) |=> (!sp_sel || $stable(sp_active)));

  assert_step_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !sp_sel) |=> (!sp_sel || sp_active == $past(step_start)));
endmodule

bind alpha_loop_ctl alpha_loop_chk #(.SP_W(SP_W), .CORR_W(CORR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .sp_sel(sp_sel),
  .opc_lvl(opc_lvl), .hold_err(hold_err), .clamp_clr(clamp_clr),
  .clamp_sticky(clamp_sticky), .corr(corr), .corr_min(corr_min),
  .corr_max(corr_max), .sp_active(sp_active), .step_start(step_start)
);

// File: tb/test_alpha_loop_ctl.sv
`timescale 1ns/1ps
module test_alpha_loop_ctl;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               smp_valid;
  logic signed [7:0]  smp_code;
  logic [3:0]         in_gain, loop_gain;
  logic               sp_sel;
  logic signed [11:0] sp_reg, step_start, step_size;
  logic [5:0]         step_limit;
  logic               opc_strobe, aez, aez_mode;
  logic signed [15:0] corr_min, corr_max;
  logic               clamp_irq_en, clamp_clr;
  logic signed [11:0] sp_active;
  logic signed [15:0] corr;
  logic               at_limit, clamp_sticky, irq;

  int checks = 0;
  int errors = 0;
  int exp_corr = 0;
  int exp_lim  = 0;

  always #10 clk = ~clk;

  alpha_loop_ctl i_alpha_loop_ctl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .in_gain(in_gain), .loop_gain(loop_gain), .sp_sel(sp_sel),
    .sp_reg(sp_reg), .step_start(step_start), .step_size(step_size),
    .step_limit(step_limit), .opc_strobe(opc_strobe), .aez(aez),
    .aez_mode(aez_mode), .corr_min(corr_min), .corr_max(corr_max),
    .clamp_irq_en(clamp_irq_en), .clamp_clr(clamp_clr),
    .sp_active(sp_active), .corr(corr), .at_limit(at_limit),
    .clamp_sticky(clamp_sticky), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One valid sample; sp, hold and zsp are what the bench expects the block to use
  task automatic do_sample(input int code, input int sp, input bit hold,
                           input bit zsp, input string tag);
    int err, acc;
    @(negedge clk);
    smp_code  = 8'(code);
    smp_valid = 1'b1;
    err = hold ? 0 : ((zsp ? 0 : sp) - code * int'(in_gain));
    acc = exp_corr + ((err * int'(loop_gain)) >>> 2);
    exp_lim = 1;
    if (acc > int'(corr_max))      exp_corr = int'(corr_max);
    else if (acc < int'(corr_min)) exp_corr = int'(corr_min);
    else begin exp_corr = acc; exp_lim = 0; end
    @(negedge clk);
    smp_valid = 1'b0;
    check({tag, " corr"}, int'(corr), exp_corr);
    check({tag, " at_limit"}, int'(at_limit), exp_lim);
  endtask

  task automatic t_reset();
    check("R1 corr", int'(corr), 0);
    check("R1 at_limit", int'(at_limit), 0);
    check("R1 sticky", int'(clamp_sticky), 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_integrate();
    sp_reg = 12'sd500; in_gain = 4'd3; loop_gain = 4'd4;
    do_sample(100, 500, 0, 0, "R2 pos");
    do_sample(-50, 500, 0, 0, "R2 neg code");
    in_gain = 4'd15;
    do_sample(127, 500, 0, 0, "R2 neg err");
    loop_gain = 4'd3;
    do_sample(127, 500, 0, 0, "R2 odd gain floor");
  endtask

  task automatic t_hold();
    int keep = int'(corr);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      smp_code = 8'(i * 37 - 90);
    end
    check("R3 no valid hold", int'(corr), keep);
  endtask

  task automatic t_regsp();
    sp_sel = 1'b0; sp_reg = 12'sd321;
    @(negedge clk);
    check("R6 sp_active reg", int'(sp_active), 321);
  endtask

  task automatic t_clamp();
    clamp_irq_en = 1'b0;
    corr_max = 16'sd1000; sp_reg = 12'sd2000; in_gain = 4'd15; loop_gain = 4'd4;
    do_sample(-128, 2000, 0, 0, "R4 max");
    check("R4 max value", int'(corr), 1000);
    check("R5 sticky set", int'(clamp_sticky), 1);
    check("R5 irq masked", int'(irq), 0);
    clamp_irq_en = 1'b1;
    @(negedge clk);
    check("R5 irq enabled", int'(irq), 1);
    clamp_clr = 1'b1;
    @(negedge clk);
    clamp_clr = 1'b0;
    check("R5 sticky cleared", int'(clamp_sticky), 0);
    check("R5 irq cleared", int'(irq), 0);
    corr_min = -16'sd800; sp_reg = -12'sd2000;
    do_sample(127, -2000, 0, 0, "R4 min");
    check("R4 min value", int'(corr), -800);
    check("R5 sticky min", int'(clamp_sticky), 1);
    corr_min = -16'sd30000; corr_max = 16'sd30000;
    sp_reg = 12'sd0; in_gain = 4'd1; loop_gain = 4'd1;
    do_sample(4, 0, 0, 0, "R4 unbounded");
    clamp_clr = 1'b1;
    @(negedge clk);
    clamp_clr = 1'b0;
  endtask

  task automatic t_aez();
    sp_sel = 1'b0; sp_reg = 12'sd400; in_gain = 4'd2; loop_gain = 4'd4;
    aez_mode = 1'b0; aez = 1'b1;
    repeat (4) @(negedge clk);
    do_sample(90, 400, 1, 0, "R9 hold err");
    do_sample(-120, 400, 1, 0, "R9 hold err 2");
    aez_mode = 1'b1;
    @(negedge clk);
    do_sample(60, 400, 0, 1, "R10 zero sp");
    aez = 1'b0;
    repeat (4) @(negedge clk);
    do_sample(60, 400, 0, 0, "R11 aez released");
  endtask

  task automatic pulse(input int high_cycles);
    @(negedge clk);
    opc_strobe = 1'b1;
    repeat (high_cycles) @(negedge clk);
    opc_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_stepper();
    step_start = 12'sd100; step_size = 12'sd25; step_limit = 6'd3;
    sp_sel = 1'b0;
    repeat (2) @(negedge clk);
    sp_sel = 1'b1;
    @(negedge clk);
    check("R7 start loaded", int'(sp_active), 100);
    pulse(3);
    check("R7 first edge R11", int'(sp_active), 125);
    pulse(8);
    check("R7 held strobe one step", int'(sp_active), 150);
    in_gain = 4'd1; loop_gain = 4'd4;
    do_sample(10, 150, 0, 0, "R7 stepper feeds error");
    pulse(3);
    check("R8 third step", int'(sp_active), 175);
    pulse(3);
    check("R8 limit reached", int'(sp_active), 175);
    sp_sel = 1'b0;
    @(negedge clk);
    sp_sel = 1'b1;
    @(negedge clk);
    check("R7 reload start", int'(sp_active), 100);
    pulse(3);
    check("R7 count cleared", int'(sp_active), 125);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_code = '0; in_gain = '0; loop_gain = '0;
    sp_sel = 1'b0; sp_reg = '0; step_start = '0; step_size = '0; step_limit = '0;
    opc_strobe = 1'b0; aez = 1'b0; aez_mode = 1'b0;
    corr_min = -16'sd30000; corr_max = 16'sd30000;
    clamp_irq_en = 1'b0; clamp_clr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_integrate();
    t_hold();
    t_regsp();
    t_clamp();
    t_aez();
    t_stepper();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule